// File: doc/BRIEF.md
# Threshold-Gated Interrupt Bid Arbiter

This block gathers interrupt requests from a fixed set of sources. Each source offers an 8-bit bid along with its request. Every cycle the block picks the highest bid among the eligible requesters. It then compares that bid with a programmable unsigned threshold and drives an active-low interrupt line from the result. The interrupt line is registered, so it follows the live arbitration one clock later.

Software sees the winner through a current-interrupt register. That register is loaded only on a snapshot event: a write to a command address, whose data is ignored, or the falling edge of an active-low interrupt-acknowledge strobe. The snapshot holds a code made of the source number and its bid. It holds zero when the winner does not beat the threshold.

A watchdog-pending input changes the rules. While it is high, only the sources marked as receivers may bid, and the threshold is not applied. A receiver with a very low bid can therefore still raise the interrupt.

Top module: `irq_bid_arbiter`

## Requirements
- R1: The threshold register is 8 bits wide, is written and read at address 0x60, and resets to 0x00.
- R2: With watchdog-pending low, `irq_n` goes low on the clock edge after the highest requesting bid becomes strictly greater than the threshold.
- R3: A winning bid equal to or below the threshold leaves `irq_n` high, and a snapshot then captures 0x000.
- R4: On equal bids the lower-numbered source wins. The code is the source number in bits [9:8] and its bid in bits [7:0].
- R5: While `wdog_pend` is high, only the receiver sources 0 and 2 take part and the threshold is ignored. Any requesting receiver drives `irq_n` low one edge later.
- R6: Any write to address 0x61 loads the current-interrupt register with the present code. The write data is ignored and the threshold is left unchanged.
- R7: A falling edge of `iack_n` loads the current-interrupt register. Holding `iack_n` low does not reload it.
- R8: The current-interrupt register reads at address 0x62, resets to 0x000, and changes only on a snapshot event.
- R9: With no eligible request, `irq_n` is high and the snapshot code is 0x000, whatever the watchdog state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 10 | Read data for `bus_addr`, combinational |
| req | input | 4 | Request line per source |
| bid | input | 32 | Packed 8-bit bids, source i in bits [8i+7:8i] |
| wdog_pend | input | 1 | Watchdog interrupt pending |
| iack_n | input | 1 | Active-low interrupt-acknowledge strobe |
| irq_n | output | 1 | Active-low interrupt request, registered |

## Verification
The results of this block fall due at different times.
- `irq_n` is valid one edge after the requests, bids, watchdog state or threshold change. The bench therefore applies stimulus at a falling edge and samples `irq_n` at the next falling edge, after exactly one rising edge.
- A snapshot from the command write or the acknowledge strobe becomes visible on the edge that samples it.
- Read data is combinational, so the bench compares `bus_rdata` a short delay after setting `bus_addr`.
- After an acknowledge, the bench changes the bids while the strobe stays low and checks one edge later that the register has not moved.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    parameter int NSRC    = 4;
    parameter int BID_W   = 8;
    parameter int ADDR_W  = 8;
    localparam int ID_W   = $clog2(NSRC);
    localparam int CODE_W = ID_W + BID_W;

    // sources that count as receivers while the watchdog is pending
    parameter logic [NSRC-1:0] RX_MASK = 4'b0101;

    parameter logic [ADDR_W-1:0] A_THRESH = 8'h60;
    parameter logic [ADDR_W-1:0] A_UPDATE = 8'h61;
    parameter logic [ADDR_W-1:0] A_CURRENT = 8'h62;

    typedef struct packed {
        logic             found;
        logic [ID_W-1:0]  id;
        logic [BID_W-1:0] bid;
    } win_t;

    function automatic logic [CODE_W-1:0] pack_code(win_t w, logic fire);
        return fire ? {w.id, w.bid} : '0;
    endfunction
endpackage

// File: rtl/irq_arb_select.sv
module irq_arb_select
    import irq_arb_pkg::*;
(
    input  logic [NSRC-1:0]       elig,
    input  logic [NSRC*BID_W-1:0] bid,
    output win_t                  win
);
    logic [BID_W-1:0] bid_a [NSRC];

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_unpack
            assign bid_a[g] = bid[g*BID_W +: BID_W];
        end
    endgenerate

    // ascending scan with strict compare keeps the lower index on ties
    always_comb begin
        win = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!win.found || bid_a[i] > win.bid)) begin
                win.found = 1'b1;
                win.id    = ID_W'(i);
                win.bid   = bid_a[i];
            end
        end
    end
endmodule

// File: rtl/irq_arb_regs.sv
module irq_arb_regs
    import irq_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BID_W-1:0]  bus_wdata,
    input  logic              iack_n,
    input  logic [CODE_W-1:0] code,
    output logic [BID_W-1:0]  thr_q,
    output logic [CODE_W-1:0] cir_q,
    output logic              snap,
    output logic [CODE_W-1:0] bus_rdata
);
    logic iack_q;

    assign snap = (bus_wr && bus_addr == A_UPDATE) || (!iack_n && iack_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q  <= '0;
            cir_q  <= '0;
            iack_q <= 1'b1;
        end else begin
            iack_q <= iack_n;
            if (bus_wr && bus_addr == A_THRESH) thr_q <= bus_wdata;
            if (snap) cir_q <= code;
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_THRESH:  bus_rdata = CODE_W'(thr_q);
            A_CURRENT: bus_rdata = cir_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_bid_arbiter.sv
module irq_bid_arbiter
    import irq_arb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wr,
    input  logic [BID_W-1:0]       bus_wdata,
    output logic [CODE_W-1:0]      bus_rdata,
    input  logic [NSRC-1:0]        req,
    input  logic [NSRC*BID_W-1:0]  bid,
    input  logic                   wdog_pend,
    input  logic                   iack_n,
    output logic                   irq_n
);
    logic [NSRC-1:0]   elig;
    win_t              win;
    logic              fire;
    logic [CODE_W-1:0] code;
    logic [BID_W-1:0]  thr_q;
    logic [CODE_W-1:0] cir_q;
    logic              snap;

    assign elig = wdog_pend ? (req & RX_MASK) : req;

    irq_arb_select u_sel (
        .elig (elig),
        .bid  (bid),
        .win  (win)
    );

    assign fire = win.found && (wdog_pend || win.bid > thr_q);
    assign code = pack_code(win, fire);

    irq_arb_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .iack_n    (iack_n),
        .code      (code),
        .thr_q     (thr_q),
        .cir_q     (cir_q),
        .snap      (snap),
        .bus_rdata (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_n <= 1'b1;
        else     irq_n <= ~fire;
    end
endmodule

// File: rtl/irq_bid_arbiter_chk.sv
module irq_bid_arbiter_chk
    import irq_arb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NSRC-1:0]   req,
    input logic              wdog_pend,
    input logic              irq_n,
    input logic [CODE_W-1:0] cir_q,
    input logic [BID_W-1:0]  thr_q,
    input logic              snap,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BID_W-1:0]  bus_wdata
);
    // R8
    cir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !snap |=> $stable(cir_q));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |=> irq_n);

    // R5
    wdog_rx_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wdog_pend && (req & RX_MASK) == '0) |=> irq_n);

    // R1
    thr_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_THRESH) |=> thr_q == $past(bus_wdata));

    // R6
    update_keeps_thr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_UPDATE) |=> $stable(thr_q));

    // R9
    idle_snap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (snap && req == '0) |=> cir_q == '0);
endmodule

bind irq_bid_arbiter irq_bid_arbiter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .wdog_pend (wdog_pend),
    .irq_n     (irq_n),
    .cir_q     (cir_q),
    .thr_q     (thr_q),
    .snap      (snap),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/test_irq_bid_arbiter.sv
module test_irq_bid_arbiter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [9:0]  bus_rdata;
    logic [3:0]  req = 4'h0;
    logic [31:0] bid = 32'h0;
    logic        wdog_pend = 1'b0;
    logic        iack_n = 1'b1;
    logic        irq_n;

    int total = 0;
    int bad = 0;
    logic [7:0] thr_m = 8'h00;
    logic [9:0] cir_m = 10'h000;

    always #10 clk = ~clk;

    irq_bid_arbiter i_irq_bid_arbiter (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req(req), .bid(bid),
        .wdog_pend(wdog_pend), .iack_n(iack_n), .irq_n(irq_n)
    );

    // model: find max bid among eligible, then lowest index holding it
    function automatic int best_bid(logic [3:0] r, logic [31:0] b, logic wd);
        int m = -1;
        for (int i = 0; i < 4; i++)
            if (r[i] && (!wd || i == 0 || i == 2) && int'(b[i*8 +: 8]) > m)
                m = int'(b[i*8 +: 8]);
        return m;
    endfunction

    function automatic logic m_fire(logic [3:0] r, logic [31:0] b, logic wd, logic [7:0] t);
        int m = best_bid(r, b, wd);
        return (m >= 0) && (wd || m > int'(t));
    endfunction

    function automatic logic [9:0] m_code(logic [3:0] r, logic [31:0] b, logic wd, logic [7:0] t);
        int m = best_bid(r, b, wd);
        if (!m_fire(r, b, wd, t)) return 10'h000;
        for (int i = 0; i < 4; i++)
            if (r[i] && (!wd || i == 0 || i == 2) && int'(b[i*8 +: 8]) == m)
                return {2'(i), 8'(m)};
        return 10'h000;
    endfunction

    task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_chk(string tag, logic [7:0] a, logic [9:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        if (a == 8'h60) thr_m = d;
        if (a == 8'h61) cir_m = m_code(req, bid, wdog_pend, thr_m);
    endtask

    task automatic set_in(logic [3:0] r, logic [31:0] b, logic wd);
        req = r; bid = b; wdog_pend = wd;
        @(posedge clk); @(negedge clk);
        check("R2/R3/R5 irq_n", 10'(irq_n), 10'(!m_fire(r, b, wd, thr_m)));
    endtask

    task automatic do_update();
        bus_write(8'h61, 8'($urandom));
        read_chk("R6 update loads code", 8'h62, cir_m);
        read_chk("R6 threshold untouched", 8'h60, 10'(thr_m));
    endtask

    task automatic do_iack();
        iack_n = 1'b0;
        cir_m = m_code(req, bid, wdog_pend, thr_m);
        @(posedge clk); @(negedge clk);
        read_chk("R7 ack loads code", 8'h62, cir_m);
        req = 4'hF; bid = 32'hFFFF_FFFF;
        @(posedge clk); @(negedge clk);
        read_chk("R7 held ack no reload", 8'h62, cir_m);
        iack_n = 1'b1;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 R8 reset state
        read_chk("R1 threshold reset", 8'h60, 10'h000);
        read_chk("R8 cir reset", 8'h62, 10'h000);
        check("R2 irq_n reset", 10'(irq_n), 10'h1);

        // R1 threshold write/read
        bus_write(8'h60, 8'h40);
        read_chk("R1 threshold readback", 8'h60, 10'h040);

        // R3 equal to threshold
        set_in(4'b0010, 32'h0000_4000, 1'b0);
        check("R3 equal no irq", 10'(irq_n), 10'h1);
        do_update();
        check("R3 equal snaps zero", cir_m, 10'h000);

        // R2 one above
        set_in(4'b0010, 32'h0000_4100, 1'b0);
        check("R2 above irq", 10'(irq_n), 10'h0);
        do_update();
        check("R2 code", cir_m, 10'h141);

        // R4 tie: sources 1 and 3 bid 0x80
        set_in(4'b1010, 32'h8000_8000, 1'b0);
        do_update();
        check("R4 tie lower wins", cir_m, 10'h180);

        // R8 no snapshot -> cir unchanged after inputs change
        set_in(4'b1000, 32'h9000_0000, 1'b0);
        read_chk("R8 holds without snapshot", 8'h62, 10'h180);

        // R5 watchdog: receiver 0 low bid beats high non-receiver
        set_in(4'b0011, 32'h0000_F005, 1'b1);
        check("R5 wdog irq", 10'(irq_n), 10'h0);
        do_update();
        check("R5 wdog receiver wins", cir_m, 10'h005);
        set_in(4'b1010, 32'hFF00_FF00, 1'b1);
        check("R5 wdog non-receivers ignored", 10'(irq_n), 10'h1);

        // R9 no request under both watchdog states
        set_in(4'b0000, 32'hFFFF_FFFF, 1'b1);
        do_update();
        check("R9 idle wdog", cir_m, 10'h000);
        set_in(4'b0000, 32'hFFFF_FFFF, 1'b0);
        check("R9 idle irq", 10'(irq_n), 10'h1);

        // R7 acknowledge directed
        set_in(4'b0100, 32'h00C3_0000, 1'b0);
        do_iack();
        check("R7 ack code", cir_m, 10'h2C3);

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [31:0] b;
            if ($urandom % 4 == 0) bus_write(8'h60, 8'($urandom));
            b = ($urandom % 2) ? 32'($urandom) : (32'($urandom) & 32'h0707_0707);
            set_in(4'($urandom), b, ($urandom % 4) == 0);
            if ($urandom % 2) do_update();
            else              do_iack();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule